// File: doc/BRIEF.md
# Descriptor-Driven Multi-Pattern Matcher

This block scans stream buffers held in local memory for a small table of exact byte patterns. Each piece of work is a descriptor carrying a start address and a byte length. When a descriptor is accepted, the block walks that memory region one byte at a time through a simple read port. It keeps a short history of the most recent bytes and compares that history against every configured pattern in parallel.

One pattern table serves all traffic, whatever its port. Each table slot holds the single longest literal string of one rule, together with a pointer to that rule's data. A hit on a rule that was meant for another port is still reported, and later verification sorts it out. Because the input buffer is a reassembled stream, a pattern that straddles the boundary between the original packets is still found.

Each rule that hits in a stream produces one match item on a shared output queue. After the last byte of the region, the block sends one end-of-stream item, even when the stream had no matches. Both queue interfaces use valid/ready. A transfer takes place on a rising clock edge where valid and ready are both high. The block holds its output item steady while `mq_ready` is low, and it stops reading memory until the item is taken, so back-pressure never loses a match. `desc_ready` is high only while the block is idle.

Top module: `stream_pattern_scanner`

## Requirements
- R1: After reset, `desc_ready` is 1, `mq_valid` is 0 and `mem_req` is 0. While `desc_ready` is high, `mq_valid` is low.
- R2: A configuration write sets three things in slot `cfg_slot`: its length from `cfg_len`, its rule pointer from `cfg_rule`, and its pattern from `cfg_pattern`. The pattern is right-aligned, so its last byte sits in bits 7:0 and its first byte sits in bits 8L-1:8L-8. A length of 0 disables the slot. After reset, every slot is disabled.
- R3: An accepted descriptor causes exactly `desc_len` reads, at addresses `desc_addr`, `desc_addr`+1, and so on upward. `mem_req` is a single-cycle pulse, never high on two consecutive cycles. `mem_rdata` is sampled in the cycle after `mem_req`. `desc_ready` stays low from acceptance until the end-of-stream item has been taken.
- R4: A slot of length L hits at a byte when the last L bytes read from the current descriptor equal its pattern. Bytes from earlier descriptors never count toward a hit.
- R5: Each hit produces an item with `mq_eos`=0 and `mq_rule` set to the slot's rule pointer. Items leave in the order of their first-hit byte. When several slots hit on the same byte, the lower slot index goes first.
- R6: Within one descriptor, a given slot produces at most one item. This suppression is cleared when the next descriptor is accepted.
- R7: After the items of the last byte, exactly one item is sent with `mq_eos`=1 and `mq_rule`=0. A zero-length descriptor produces only this item. Once this item is taken, `desc_ready` returns high.
- R8: While `mq_valid` is high and `mq_ready` is low, `mq_valid`, `mq_eos` and `mq_rule` hold their values. No memory read is issued while an item is pending. No item is ever dropped.
- R9: A pattern of the full maximum length (8 bytes by default) is found, and a stream that ends one byte short of such a pattern produces no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Pattern slot write strobe |
| cfg_slot | input | 3 | Slot index to write |
| cfg_len | input | 4 | Pattern length in bytes; 0 disables the slot |
| cfg_pattern | input | 64 | Right-aligned pattern bytes |
| cfg_rule | input | 16 | Rule pointer stored with the slot |
| desc_valid | input | 1 | Work descriptor valid |
| desc_ready | output | 1 | Block idle and accepting a descriptor |
| desc_addr | input | 16 | Region start address |
| desc_len | input | 16 | Region length in bytes |
| mem_req | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_req` |
| mq_valid | output | 1 | Match queue item valid |
| mq_ready | input | 1 | Match queue can accept |
| mq_eos | output | 1 | Item is the end-of-stream marker |
| mq_rule | output | 16 | Rule pointer of the matched rule, 0 for end-of-stream |

## Verification
The scanner is exercised with several kinds of stream, each aimed at a different fault:

- A repeating stream (`abcabcab`), where two slots hit on the same byte and one pattern recurs. It separates correct same-byte priority from wrong priority, and deduplication from repeated items.
- An eight-byte pattern hidden inside a longer stream, plus a copy of that stream cut one byte short. Together they test the full history width and the fill gating.
- Two adjacent descriptors whose combined bytes would form a pattern that neither holds alone. This shows whether the history leaks across descriptors.
- A zero-length descriptor, a stream that matches only a disabled slot, and the same stream again after that slot is enabled. These show that the end-of-stream marker appears alone and that a length of 0 truly disables a slot.
- The whole sequence, rerun under pseudo-random `mq_ready` stalls. This shows whether any item is lost or reordered.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_DATA,
    ST_SCAN,
    ST_EOS
  } spm_state_e;
endpackage

// File: rtl/spm_pattern_bank.sv
// Holds the pattern slots and compares them all against the byte history.
module spm_pattern_bank #(
  parameter int NPAT   = 8,
  parameter int MAXLEN = 8,
  parameter int RW     = 16,
  localparam int IW    = $clog2(NPAT),
  localparam int FW    = $clog2(MAXLEN + 1),
  localparam int HW    = 8 * MAXLEN
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [IW-1:0]            cfg_slot,
  input  logic [FW-1:0]            cfg_len,
  input  logic [HW-1:0]            cfg_pattern,
  input  logic [RW-1:0]            cfg_rule,
  input  logic [HW-1:0]            hist,
  input  logic [FW-1:0]            fill,
  output logic [NPAT-1:0]          hit,
  output logic [NPAT-1:0][RW-1:0]  rules
);

  for (genvar g = 0; g < NPAT; g++) begin : g_slot
    logic [FW-1:0] len_q;
    logic [HW-1:0] pat_q;
    logic [RW-1:0] rule_q;
    logic [HW-1:0] msk;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        len_q  <= '0;
        pat_q  <= '0;
        rule_q <= '0;
      end else if (cfg_we && cfg_slot == IW'(g)) begin
        len_q  <= cfg_len;
        pat_q  <= cfg_pattern;
        rule_q <= cfg_rule;
      end
    end

    // Only the newest len_q bytes of the history take part in the compare.
    always_comb begin
      msk = '0;
      for (int k = 0; k < MAXLEN; k++) begin
        if (FW'(k) < len_q) msk[8*k +: 8] = 8'hFF;
      end
    end

    assign hit[g]   = (len_q != '0) && (fill >= len_q) &&
                      (((hist ^ pat_q) & msk) == '0);
    assign rules[g] = rule_q;
  end

endmodule

// File: rtl/spm_seq.sv
// Accepts descriptors, walks the memory region and keeps the byte history.
module spm_seq
  import spm_pkg::*;
#(
  parameter int AW     = 16,
  parameter int LW     = 16,
  parameter int MAXLEN = 8,
  localparam int FW    = $clog2(MAXLEN + 1),
  localparam int HW    = 8 * MAXLEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_valid,
  output logic          desc_ready,
  input  logic [AW-1:0] desc_addr,
  input  logic [LW-1:0] desc_len,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  input  logic          pend_any,
  input  logic          eos_taken,
  output logic [HW-1:0] hist,
  output logic [FW-1:0] fill,
  output logic          scan,
  output logic          eos,
  output logic          clr
);

  spm_state_e    state_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q;
  logic [HW-1:0] hist_q;
  logic [FW-1:0] fill_q;

  assign desc_ready = (state_q == ST_IDLE);
  assign mem_req    = (state_q == ST_REQ);
  assign mem_addr   = addr_q;
  assign scan       = (state_q == ST_SCAN);
  assign eos        = (state_q == ST_EOS);
  assign clr        = desc_valid && desc_ready;
  assign hist       = hist_q;
  assign fill       = fill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      hist_q  <= '0;
      fill_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (clr) begin
          addr_q  <= desc_addr;
          rem_q   <= desc_len;
          hist_q  <= '0;
          fill_q  <= '0;
          state_q <= (desc_len == '0) ? ST_EOS : ST_REQ;
        end
        ST_REQ:  state_q <= ST_DATA;
        ST_DATA: begin
          hist_q  <= {hist_q[HW-9:0], mem_rdata};
          if (fill_q != FW'(MAXLEN)) fill_q <= fill_q + 1'b1;
          addr_q  <= addr_q + 1'b1;
          rem_q   <= rem_q - 1'b1;
          state_q <= ST_SCAN;
        end
        ST_SCAN: if (!pend_any) state_q <= (rem_q == '0) ? ST_EOS : ST_REQ;
        ST_EOS:  if (eos_taken) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spm_emitter.sv
// Turns new hits into queue items, lowest slot first, once per stream.
module spm_emitter #(
  parameter int NPAT = 8,
  parameter int RW   = 16,
  localparam int IW  = $clog2(NPAT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     scan,
  input  logic                     eos,
  input  logic [NPAT-1:0]          hit,
  input  logic [NPAT-1:0][RW-1:0]  rules,
  input  logic                     mq_ready,
  output logic                     mq_valid,
  output logic                     mq_eos,
  output logic [RW-1:0]            mq_rule,
  output logic                     pend_any,
  output logic                     eos_taken
);

  logic [NPAT-1:0] seen_q;
  logic [NPAT-1:0] pend;
  logic [IW-1:0]   sel;
  logic            found;

  assign pend     = hit & ~seen_q;
  assign pend_any = |pend;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NPAT; i++) begin
      if (pend[i] && !found) begin
        sel   = IW'(i);
        found = 1'b1;
      end
    end
  end

  assign mq_valid  = (scan && pend_any) || eos;
  assign mq_eos    = eos;
  assign mq_rule   = eos ? '0 : rules[sel];
  assign eos_taken = eos && mq_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (clr) begin
      seen_q <= '0;
    end else if (scan && pend_any && mq_ready) begin
      seen_q[sel] <= 1'b1;
    end
  end

endmodule

// File: rtl/stream_pattern_scanner.sv
module stream_pattern_scanner #(
  parameter int NPAT   = 8,
  parameter int MAXLEN = 8,
  parameter int AW     = 16,
  parameter int LW     = 16,
  parameter int RW     = 16,
  localparam int IW    = $clog2(NPAT),
  localparam int FW    = $clog2(MAXLEN + 1),
  localparam int HW    = 8 * MAXLEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_slot,
  input  logic [FW-1:0] cfg_len,
  input  logic [HW-1:0] cfg_pattern,
  input  logic [RW-1:0] cfg_rule,
  input  logic          desc_valid,
  output logic          desc_ready,
  input  logic [AW-1:0] desc_addr,
  input  logic [LW-1:0] desc_len,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          mq_valid,
  input  logic          mq_ready,
  output logic          mq_eos,
  output logic [RW-1:0] mq_rule
);

  logic [HW-1:0]           hist;
  logic [FW-1:0]           fill;
  logic                    scan;
  logic                    eos_st;
  logic                    clr;
  logic                    pend_any;
  logic                    eos_taken;
  logic [NPAT-1:0]         hit;
  logic [NPAT-1:0][RW-1:0] rules;

  spm_pattern_bank #(.NPAT(NPAT), .MAXLEN(MAXLEN), .RW(RW)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_len(cfg_len), .cfg_pattern(cfg_pattern), .cfg_rule(cfg_rule),
    .hist(hist), .fill(fill), .hit(hit), .rules(rules)
  );

  spm_seq #(.AW(AW), .LW(LW), .MAXLEN(MAXLEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_addr(desc_addr), .desc_len(desc_len), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .pend_any(pend_any),
    .eos_taken(eos_taken), .hist(hist), .fill(fill), .scan(scan),
    .eos(eos_st), .clr(clr)
  );

  spm_emitter #(.NPAT(NPAT), .RW(RW)) u_emit (
    .clk(clk), .rst_n(rst_n), .clr(clr), .scan(scan), .eos(eos_st),
    .hit(hit), .rules(rules), .mq_ready(mq_ready), .mq_valid(mq_valid),
    .mq_eos(mq_eos), .mq_rule(mq_rule), .pend_any(pend_any),
    .eos_taken(eos_taken)
  );

endmodule

// File: rtl/spm_checker.sv
module spm_checker #(
  parameter int RW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          desc_valid,
  input logic          desc_ready,
  input logic          mem_req,
  input logic          mq_valid,
  input logic          mq_ready,
  input logic          mq_eos,
  input logic [RW-1:0] mq_rule
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> !mq_valid);

  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R3
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !desc_ready);

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_ready) |=> !desc_ready);

  // R7
  eos_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mq_valid && mq_ready && mq_eos) |=> desc_ready);

  // R8
  hold_item_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mq_valid && !mq_ready) |=> (mq_valid && $stable(mq_eos) && $stable(mq_rule)));

  // R8
  stall_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mq_valid |-> !mem_req);

endmodule

bind stream_pattern_scanner spm_checker #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .mem_req(mem_req), .mq_valid(mq_valid), .mq_ready(mq_ready),
  .mq_eos(mq_eos), .mq_rule(mq_rule)
);

// File: tb/stream_pattern_scanner_tb.sv
`timescale 1ns/1ps
module stream_pattern_scanner_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_slot = '0;
  logic [3:0]  cfg_len = '0;
  logic [63:0] cfg_pattern = '0;
  logic [15:0] cfg_rule = '0;
  logic        desc_valid = 1'b0;
  logic        desc_ready;
  logic [15:0] desc_addr = '0;
  logic [15:0] desc_len = '0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        mq_valid;
  logic        mq_ready = 1'b1;
  logic        mq_eos;
  logic [15:0] mq_rule;

  always #2 clk = ~clk;

  stream_pattern_scanner u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_len(cfg_len), .cfg_pattern(cfg_pattern), .cfg_rule(cfg_rule),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
    .desc_len(desc_len), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mq_valid(mq_valid), .mq_ready(mq_ready),
    .mq_eos(mq_eos), .mq_rule(mq_rule)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [7:0]  mem [0:255];
  logic [63:0] tp [8];
  logic [3:0]  tl [8];
  logic [15:0] tr [8];
  logic [16:0] exp_q [$];
  int   rd_cnt = 0;
  int   rd_start = 0;
  int   rd_base = 0;
  int   rd_len = 0;
  logic stall_mode = 1'b0;
  logic [7:0] lf = 8'h5A;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Memory with one cycle of read latency
  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[7:0]];

  // R3: read order check, sampled between edges
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      chk(int'(mem_addr) == rd_base + (rd_cnt - rd_start), "R3", "read address",
          int'(mem_addr), rd_base + (rd_cnt - rd_start));
      rd_cnt++;
    end
  end

  // Monitor: drive ready, then compare the item that will transfer at the next edge
  always @(negedge clk) begin
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    mq_ready <= stall_mode ? lf[0] : 1'b1;
    #1;
    if (rst_n && mq_valid && mq_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected item", int'({mq_eos, mq_rule}), 0);
      end else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        chk(mq_eos == e[16], "R7", "item kind", int'(mq_eos), int'(e[16]));
        chk(mq_rule == e[15:0], "R5", "rule pointer", int'(mq_rule), int'(e[15:0]));
        if (mq_eos) chk(rd_cnt - rd_start == rd_len, "R3", "read count",
                        rd_cnt - rd_start, rd_len);
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      fails++;
      $display("FAIL R8 watchdog: actual hung, expected completion");
      summary();
      $finish;
    end
  end

  task automatic put_str(input int addr, input string s);
    for (int i = 0; i < s.len(); i++) mem[addr + i] = s[i];
  endtask

  task automatic cfg(input int slot, input int len, input logic [63:0] pat,
                     input logic [15:0] rule);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = 3'(slot); cfg_len = 4'(len);
    cfg_pattern = pat; cfg_rule = rule;
    tp[slot] = pat; tl[slot] = 4'(len); tr[slot] = rule;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Driver: predicts items from the requirements, then issues the descriptor
  task automatic send(input int addr, input int len);
    for (int p = 0; p < len; p++) begin
      for (int i = 0; i < 8; i++) begin
        bit m;
        bit dup;
        m = (tl[i] != 0) && (p + 1 >= int'(tl[i]));
        for (int k = 0; k < 8; k++)
          if (m && k < int'(tl[i]) && mem[8'(addr + p - k)] != tp[i][8*k +: 8]) m = 0;
        dup = 0;
        for (int q = 0; q < p && m; q++) begin
          bit mq;
          mq = (q + 1 >= int'(tl[i]));
          for (int k = 0; k < 8; k++)
            if (mq && k < int'(tl[i]) && mem[8'(addr + q - k)] != tp[i][8*k +: 8]) mq = 0;
          if (mq) dup = 1;
        end
        if (m && !dup) exp_q.push_back({1'b0, tr[i]});
      end
    end
    exp_q.push_back({1'b1, 16'h0000});
    @(negedge clk);
    while (!desc_ready) @(negedge clk);
    rd_base = addr; rd_len = len; rd_start = rd_cnt;
    desc_valid = 1'b1; desc_addr = 16'(addr); desc_len = 16'(len);
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !desc_ready) @(negedge clk);
  endtask

  task automatic run_set();
    send(0, 8);    // R5 R6: abcabcab
    send(16, 12);  // R9: eight-byte pattern inside
    send(16, 9);   // R9: one byte short
    send(32, 0);   // R7: zero length
    send(48, 2);   // R4: "xa"
    send(50, 2);   // R4: "bc" alone, no cross-descriptor abc
    send(64, 4);   // R2: only disabled slot would match
    send(0, 8);    // R6: suppression cleared on new descriptor
    drain();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h2E;
    put_str(0, "abcabcab");
    put_str(16, "xxGET /admin");
    put_str(48, "xabc");
    put_str(64, "zzzz");
    for (int i = 0; i < 8; i++) begin tp[i] = '0; tl[i] = '0; tr[i] = '0; end

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(desc_ready == 1'b1, "R1", "desc_ready in reset", int'(desc_ready), 1);
    chk(mq_valid == 1'b0, "R1", "mq_valid in reset", int'(mq_valid), 0);
    chk(mem_req == 1'b0, "R1", "mem_req in reset", int'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(desc_ready == 1'b1, "R1", "desc_ready after reset", int'(desc_ready), 1);

    // R2: right-aligned patterns, slot 5 disabled by length 0
    cfg(0, 3, 64'("abc"), 16'h0A00);
    cfg(1, 2, 64'("bc"), 16'h0A01);
    cfg(2, 3, 64'("xyz"), 16'h0A02);
    cfg(3, 1, 64'("q"), 16'h0A03);
    cfg(4, 8, 64'("GET /adm"), 16'h0A04);
    cfg(5, 0, 64'("zz"), 16'h0A05);
    cfg(6, 3, 64'("cab"), 16'h0A06);

    stall_mode = 1'b0;
    run_set();
    // R8: same sequence under random back-pressure
    stall_mode = 1'b1;
    run_set();

    // R2: enabling slot 5 makes the stream at 64 report it once
    stall_mode = 1'b0;
    cfg(5, 2, 64'("zz"), 16'h0A05);
    send(64, 4);
    drain();

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "items outstanding", exp_q.size(), 0);
    chk(mq_valid == 1'b0, "R7", "idle after last stream", int'(mq_valid), 0);
    summary();
    $finish;
  end

endmodule